// File: doc/BRIEF.md
# Speculative Line Tracker with Commit Snooping

This block is the speculation bookkeeping of a small direct-mapped tag store that sits beside a processor running every piece of work as a transaction. Each line holds a valid flag, a full tag, a data word and two speculation flags. One flag records that the running transaction loaded from the line. The other records that the transaction stored to it. Loads and stores arrive on a processor port together with a level that says a transaction is running. A pulse on a separate input marks a successful local commit.

Other processors publish their committed writes as a stream of beats. Each beat carries a line address and may also carry a data word. The block looks every beat up in its own lines. A beat with data refreshes the matching line. A beat without data drops the matching line. A beat that lands on a line the local transaction has read is a dependence violation. In that case the block raises a one-cycle restart pulse and rolls the transaction back: every line the transaction stored to is dropped, and all speculation flags clear.

The lookup outputs show the registered state of the line at the presented address. The bench uses them to observe the line state without changing it.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset, no address hits, all speculation flags read 0, and `viol` is low.
- R2: A load with `tx_active` high sets the read flag of its line. A load with `tx_active` low sets no flag.
- R3: A store writes `cpu_data` into its line. With `tx_active` high it also sets the line's modified flag. A store with `tx_active` low sets no flag.
- R4: A snoop beat that hits a line whose read flag is set, while `tx_active` is high, raises `viol` for exactly one cycle. `viol` rises in the cycle after the beat.
- R5: In the cycle of a violation, every line with its modified flag set becomes invalid and all flags clear. A local access presented in that same cycle is ignored.
- R6: A hitting snoop beat with `snp_has_data`=1 replaces the line's data and leaves the line valid. A hitting beat with `snp_has_data`=0 invalidates the line.
- R7: A snoop hits only when the line at index `snp_addr[IDX_W-1:0]` is valid and its stored tag equals `snp_addr[AW-1:IDX_W]` in full. A beat that does not hit has no effect.
- R8: A `tx_commit` pulse clears every read and modified flag. The lines stay valid and keep their data.
- R9: After a violation, no further violation is reported and no flag is set until `tx_active` has been low for at least one cycle. `viol` never follows a cycle with `tx_active` low.
- R10: When a local access and a snoop beat touch the same line in the same cycle, the snoop takes effect first. The access is then applied to the line as the snoop left it.
- R11: An access that misses allocates the line at its index with the new tag, data `cpu_data` and fresh flags. A load that hits leaves the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Local access present |
| cpu_write | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | TAG_W+IDX_W | Line address: tag in the upper bits, index in the lower bits |
| cpu_data | input | DATA_W | Store data, or fill data for a load miss |
| tx_active | input | 1 | A local transaction is running |
| tx_commit | input | 1 | Local transaction committed; clears the flags |
| snp_valid | input | 1 | Commit beat from another processor present |
| snp_has_data | input | 1 | Beat carries a data word (update) rather than address only (invalidate) |
| snp_addr | input | TAG_W+IDX_W | Line address of the beat |
| snp_data | input | DATA_W | Data word of the beat |
| cpu_hit | output | 1 | Line at `cpu_addr` is valid with a matching tag |
| cpu_rdata | output | DATA_W | Data word of the line at the index of `cpu_addr` |
| cpu_spec_rd | output | 1 | Hit and read flag set |
| cpu_spec_md | output | 1 | Hit and modified flag set |
| viol | output | 1 | One-cycle restart pulse after a dependence violation |

## Verification
The bench builds the block with IDX_W=2 and TAG_W=2. That gives four lines and only sixteen line addresses, so random loads, stores and snoop beats collide often. Tag mismatches at an occupied index, same-cycle clashes between a snoop and an access on one line, and refills of lines that a snoop has just dropped all occur many times per run. The bench also uses DATA_W=8, which keeps the data values distinct enough to show whether an update or a store won.

// File: rtl/spec_line_tracker.sv
module spec_line_tracker #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_valid,
  input  logic                   cpu_write,
  input  logic [TAG_W+IDX_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0]      cpu_data,
  input  logic                   tx_active,
  input  logic                   tx_commit,
  input  logic                   snp_valid,
  input  logic                   snp_has_data,
  input  logic [TAG_W+IDX_W-1:0] snp_addr,
  input  logic [DATA_W-1:0]      snp_data,
  output logic                   cpu_hit,
  output logic [DATA_W-1:0]      cpu_rdata,
  output logic                   cpu_spec_rd,
  output logic                   cpu_spec_md,
  output logic                   viol
);
  localparam int LINES = 1 << IDX_W;
  localparam int AW    = TAG_W + IDX_W;

  logic [LINES-1:0]  vld, rd, md, nvld, nrd, nmd;
  logic [TAG_W-1:0]  tags [LINES];
  logic [TAG_W-1:0]  ntag [LINES];
  logic [DATA_W-1:0] dats [LINES];
  logic [DATA_W-1:0] ndat [LINES];
  logic              seen;

  wire [IDX_W-1:0] ci = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] ct = cpu_addr[AW-1:IDX_W];
  wire [IDX_W-1:0] si = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] st = snp_addr[AW-1:IDX_W];

  wire spec    = tx_active & ~seen;
  wire snp_hit = snp_valid & vld[si] & (tags[si] == st);
  wire fire    = snp_hit & rd[si] & spec;

  assign cpu_hit     = vld[ci] & (tags[ci] == ct);
  assign cpu_rdata   = dats[ci];
  assign cpu_spec_rd = cpu_hit & rd[ci];
  assign cpu_spec_md = cpu_hit & md[ci];

  always_comb begin
    nvld = vld;
    nrd  = rd;
    nmd  = md;
    ntag = tags;
    ndat = dats;
    if (snp_hit) begin
      if (snp_has_data) ndat[si] = snp_data;
      else begin
        nvld[si] = 1'b0;
        nrd[si]  = 1'b0;
        nmd[si]  = 1'b0;
      end
    end
    if (fire) begin
      nvld = nvld & ~nmd;
      nrd  = '0;
      nmd  = '0;
    end else if (cpu_valid) begin
      if (!(nvld[ci] && ntag[ci] == ct)) begin
        nvld[ci] = 1'b1;
        ntag[ci] = ct;
        ndat[ci] = cpu_data;
        nrd[ci]  = 1'b0;
        nmd[ci]  = 1'b0;
      end else if (cpu_write) begin
        ndat[ci] = cpu_data;
      end
      if (spec) begin
        if (cpu_write) nmd[ci] = 1'b1;
        else           nrd[ci] = 1'b1;
      end
    end
    if (tx_commit) begin
      nrd = '0;
      nmd = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      rd   <= '0;
      md   <= '0;
      seen <= 1'b0;
      viol <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        tags[i] <= '0;
        dats[i] <= '0;
      end
    end else begin
      vld  <= nvld;
      rd   <= nrd;
      md   <= nmd;
      tags <= ntag;
      dats <= ndat;
      viol <= fire;
      seen <= tx_active & (seen | fire);
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> !viol);
  a_r5_rollback_clears: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (rd == '0) && (md == '0));
  a_r8_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_commit) |-> (rd == '0) && (md == '0));
  a_r9_no_viol_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> !viol);
  a_r2_flags_need_tx: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd & ~$past(rd)) != '0) || ((md & ~$past(md)) != '0) |-> $past(tx_active));
endmodule

// File: tb/spec_line_tracker_test.sv
module spec_line_tracker_test;
  localparam int IDX_W = 2, TAG_W = 2, DW = 8;
  localparam int AW = IDX_W + TAG_W, LINES = 1 << IDX_W;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_write = 0, tx_active = 0, tx_commit = 0;
  logic snp_valid = 0, snp_has_data = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [DW-1:0] cpu_data = '0, snp_data = '0;
  logic cpu_hit, cpu_spec_rd, cpu_spec_md, viol;
  logic [DW-1:0] cpu_rdata;

  spec_line_tracker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .tx_active(tx_active),
    .tx_commit(tx_commit), .snp_valid(snp_valid), .snp_has_data(snp_has_data),
    .snp_addr(snp_addr), .snp_data(snp_data), .cpu_hit(cpu_hit),
    .cpu_rdata(cpu_rdata), .cpu_spec_rd(cpu_spec_rd), .cpu_spec_md(cpu_spec_md),
    .viol(viol));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit m_vld [LINES], m_rd [LINES], m_md [LINES];
  logic [TAG_W-1:0] m_tag [LINES];
  logic [DW-1:0] m_dat [LINES];
  bit m_seen = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic model(bit cv, bit cw, logic [AW-1:0] ca, logic [DW-1:0] cd,
                       bit ta, bit tc, bit sv, bit sdv, logic [AW-1:0] sa,
                       logic [DW-1:0] sd, output bit f);
    int ci = int'(ca[IDX_W-1:0]);
    int si = int'(sa[IDX_W-1:0]);
    bit spec = ta && !m_seen;
    bit sh = sv && m_vld[si] && m_tag[si] == sa[AW-1:IDX_W];
    f = sh && m_rd[si] && spec;
    if (sh) begin
      if (sdv) m_dat[si] = sd;
      else begin m_vld[si] = 0; m_rd[si] = 0; m_md[si] = 0; end
    end
    if (f) begin
      for (int i = 0; i < LINES; i++) begin
        if (m_md[i]) m_vld[i] = 0;
        m_rd[i] = 0; m_md[i] = 0;
      end
    end else if (cv) begin
      if (!(m_vld[ci] && m_tag[ci] == ca[AW-1:IDX_W])) begin
        m_vld[ci] = 1; m_tag[ci] = ca[AW-1:IDX_W]; m_dat[ci] = cd;
        m_rd[ci] = 0; m_md[ci] = 0;
      end else if (cw) m_dat[ci] = cd;
      if (spec) begin
        if (cw) m_md[ci] = 1; else m_rd[ci] = 1;
      end
    end
    if (tc) for (int i = 0; i < LINES; i++) begin m_rd[i] = 0; m_md[i] = 0; end
    m_seen = ta && (m_seen || f);
  endtask

  task automatic step(bit cv, bit cw, logic [AW-1:0] ca, logic [DW-1:0] cd,
                      bit ta, bit tc, bit sv, bit sdv, logic [AW-1:0] sa,
                      logic [DW-1:0] sd, string tg);
    int ci = int'(ca[IDX_W-1:0]);
    bit eh, f;
    @(negedge clk);
    cpu_valid = cv; cpu_write = cw; cpu_addr = ca; cpu_data = cd;
    tx_active = ta; tx_commit = tc; snp_valid = sv; snp_has_data = sdv;
    snp_addr = sa; snp_data = sd;
    #1;
    eh = m_vld[ci] && m_tag[ci] == ca[AW-1:IDX_W];
    chk({tg, " hit"}, cpu_hit, eh);
    if (eh) begin
      chk({tg, " data"}, cpu_rdata, m_dat[ci]);
      chk({tg, " rd flag"}, cpu_spec_rd, m_rd[ci]);
      chk({tg, " md flag"}, cpu_spec_md, m_md[ci]);
    end
    model(cv, cw, ca, cd, ta, tc, sv, sdv, sa, sd, f);
    @(posedge clk); #1;
    chk("R4 viol timing", viol, f);
  endtask

  task automatic probe(logic [AW-1:0] a, bit ta, string tg);
    step(0, 0, a, 0, ta, 0, 0, 0, 0, 0, tg);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [AW-1:0] A = 4'b0100, B = 4'b0101, C = 4'b0110, D = 4'b0111;

  initial begin
    int r;
    bit tx;
    r = $urandom(2024);
    for (int i = 0; i < LINES; i++) begin
      m_vld[i] = 0; m_rd[i] = 0; m_md[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int a = 0; a < 16; a++) begin
      probe(AW'(a), 0, "R1");
      chk("R1 no hit", cpu_hit, 0);
      chk("R1 viol low", viol, 0);
    end
    step(1, 0, A, 8'h11, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 0, C, 8'h33, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 0, D, 8'h44, 0, 0, 0, 0, 0, 0, "R11");
    probe(A, 0, "R2");
    chk("R2 load outside tx no flag", cpu_spec_rd, 0);
    chk("R11 fill data", cpu_rdata, 8'h11);
    step(1, 0, A, 8'h99, 1, 0, 0, 0, 0, 0, "R2");
    probe(A, 1, "R2");
    chk("R2 read flag set", cpu_spec_rd, 1);
    chk("R11 load hit keeps data", cpu_rdata, 8'h11);
    step(1, 1, B, 8'h22, 1, 0, 0, 0, 0, 0, "R3");
    probe(B, 1, "R3");
    chk("R3 modified flag", cpu_spec_md, 1);
    chk("R3 store data", cpu_rdata, 8'h22);
    step(0, 0, A, 0, 1, 0, 1, 0, 4'b1000, 0, "R7");
    chk("R7 tag mismatch no viol", viol, 0);
    probe(A, 1, "R7");
    chk("R7 line kept", cpu_hit, 1);
    step(0, 0, C, 0, 1, 0, 1, 0, C, 0, "R6");
    probe(C, 1, "R6");
    chk("R6 address-only invalidates", cpu_hit, 0);
    step(0, 0, D, 0, 1, 0, 1, 1, D, 8'h5A, "R6");
    probe(D, 1, "R6");
    chk("R6 update keeps line", cpu_hit, 1);
    chk("R6 update data", cpu_rdata, 8'h5A);
    step(1, 1, D, 8'hEE, 1, 0, 1, 1, A, 8'h77, "R5");
    chk("R4 violation pulse", viol, 1);
    probe(B, 1, "R5");
    chk("R4 pulse ends", viol, 0);
    chk("R5 modified line dropped", cpu_hit, 0);
    probe(D, 1, "R5");
    chk("R5 same-cycle store ignored", cpu_rdata, 8'h5A);
    probe(A, 1, "R5");
    chk("R5 read flag cleared", cpu_spec_rd, 0);
    chk("R5 read line updated kept", cpu_rdata, 8'h77);
    step(1, 0, A, 0, 1, 0, 0, 0, 0, 0, "R9");
    probe(A, 1, "R9");
    chk("R9 no flag while violated", cpu_spec_rd, 0);
    step(0, 0, A, 0, 1, 0, 1, 1, A, 8'h78, "R9");
    chk("R9 no second violation", viol, 0);
    probe(A, 0, "R9");
    step(1, 1, D, 8'hC3, 1, 0, 1, 1, D, 8'h3C, "R10");
    chk("R10 no viol", viol, 0);
    probe(D, 1, "R10");
    chk("R10 store after update", cpu_rdata, 8'hC3);
    chk("R10 md set", cpu_spec_md, 1);
    step(1, 0, A, 8'hAB, 1, 0, 1, 0, A, 0, "R10");
    probe(A, 1, "R10");
    chk("R10 refill after invalidate", cpu_rdata, 8'hAB);
    chk("R10 rd set", cpu_spec_rd, 1);
    step(0, 0, A, 0, 1, 1, 0, 0, 0, 0, "R8");
    probe(A, 1, "R8");
    chk("R8 rd cleared", cpu_spec_rd, 0);
    chk("R8 line valid", cpu_hit, 1);
    probe(D, 1, "R8");
    chk("R8 md cleared", cpu_spec_md, 0);
    chk("R8 data kept", cpu_rdata, 8'hC3);

    tx = 1;
    for (int n = 0; n < 4000; n++) begin
      bit tc, sv, cv;
      if ($urandom_range(0, 19) == 0) tx = !tx;
      tc = tx && $urandom_range(0, 24) == 0;
      sv = $urandom_range(0, 2) == 0;
      cv = $urandom_range(0, 1) == 0;
      step(cv, 1'($urandom), AW'($urandom), DW'($urandom), tx, tc, sv,
           1'($urandom), AW'($urandom), DW'($urandom), "R10 random");
    end
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule